// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a CPU bus and a small on-chip flash array. The CPU writes one-byte command codes; some of them need a second write that carries an address and data. The block decodes these sequences and starts program and erase operations on the array. It keeps an 8-bit status byte and drives a ready flag. It also chooses whether a CPU read returns array contents or the status byte.

Commands are honoured only while the rewrite enable input is high. Program and erase run for a fixed number of clock cycles, set by parameters. While they run, the block is busy and drops every further write. When an operation starts, the read path turns to the status byte by itself and stays there until the CPU asks for array reads again. The flash array is modelled behaviourally. A program can only clear bits. An erase fills one block with 0xFF.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80, ready_o is 1, reads return array data, and every array byte is 0xFF. Status bits 6 and 3..0 are always 0.
- R2: A write while rewrite_en is 0 has no effect on the sequence, the read selection, the status byte or the array.
- R3: Writing 0xFF as a first-cycle command selects array reads. A read strobe sampled at a clock edge puts the byte at cpu_addr on cpu_rdata after that edge.
- R4: Writing 0x70 as a first-cycle command selects status reads. A read then returns the status byte, laid out as bit 7 ready, bit 5 erase error, bit 4 program error.
- R5: Writing 0x50 as a first-cycle command clears status bits 5 and 4 and leaves bit 7 unchanged.
- R6: Writing 0x40 arms a program. The next accepted write stores (old byte AND write data) at its address, and the read selection switches to status.
- R7: Writing 0x20 and then 0xD0 together with an address erases every byte whose address shares bits ADDR_W-1..BLK_W with that address, setting each to 0xFF. Bytes outside that block keep their values, and the read selection switches to status.
- R8: From the clock edge that accepts the second write, ready_o and status bit 7 read 0 for exactly PROG_CYCLES clocks for a program, or ERASE_CYCLES clocks for an erase. After that both read 1. ready_o always equals status bit 7.
- R9: If a program leaves the stored byte unequal to the write data, status bit 4 is set when the operation completes.
- R10: After 0x20, a second write whose data is not 0xD0 sets status bits 5 and 4, erases nothing, and returns the block to waiting for a first-cycle command.
- R11: Writes that arrive while ready_o is 0 are dropped, including one sampled on the same edge on which the operation completes.
- R12: The status read selection set by a program or erase stays in force after completion, until 0xFF is written.
- R13: A first-cycle code that is not one of 0xFF, 0x70, 0x50, 0x40 or 0x20 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rewrite_en | input | 1 | Enables command writes when 1 |
| cpu_addr | input | ADDR_W | Byte address for reads and second-cycle writes |
| cpu_wdata | input | 8 | Write data / command code |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| cpu_rd | input | 1 | Read strobe, sampled on the rising edge |
| cpu_rdata | output | 8 | Registered read data (array byte or status byte) |
| ready_o | output | 1 | 1 when idle, 0 while program or erase runs |

## Verification
Two things can happen on the same clock edge: an operation finishes, and the CPU issues a write together with a read. The bench arms a program, counts the busy cycles, and in the final busy cycle drives the 0xFF command together with a read strobe. It then expects three results. The read returns the status byte with bit 7 still 0. ready_o rises after that edge. The next read still returns status, which shows that the 0xFF write was dropped and that the program did land in the array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_PROG,
        ST_ARM_ERASE,
        ST_BUSY_PROG,
        ST_BUSY_ERASE
    } seq_state_e;

    typedef enum logic {
        RD_ARRAY,
        RD_STATUS
    } rd_sel_e;

    localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS   = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_PROGRAM       = 8'h40;
    localparam logic [7:0] CMD_ERASE         = 8'h20;
    localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;

    localparam int SR_READY     = 7;
    localparam int SR_ERASE_ERR = 5;
    localparam int SR_PROG_ERR  = 4;

    localparam logic [7:0] STATUS_RESET = 8'h80;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic erase_i,
    output logic busy_o,
    output logic done_o
);
    localparam int MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.cnt = erase_i ? CNT_W'(ERASE_CYCLES) : CNT_W'(PROG_CYCLES);
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = (t_q.cnt != '0);
    assign done_o = (t_q.cnt == CNT_W'(1));

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (t_q.cnt == '0));

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= CNT_W'(MAX_CYCLES));

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [7:0]        prog_data,
    output logic [7:0]        cpu_byte,
    output logic [7:0]        op_byte
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_en && ((ADDR_W'(i) >> BLK_W) == (op_addr >> BLK_W))) begin
                mem_d[i] = 8'hFF;
            end
        end
        if (prog_en) begin
            mem_d[op_addr] = mem_q[op_addr] & prog_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign cpu_byte = mem_q[cpu_addr];
    assign op_byte  = mem_q[op_addr];

    // R6
    single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && erase_en));

    // R7
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (op_byte == 8'hFF));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewrite_en,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic [7:0]        cpu_byte,
    input  logic [7:0]        op_byte,
    input  logic              tmr_done,
    output logic              tmr_start,
    output logic              tmr_erase,
    output logic              prog_en,
    output logic              erase_en,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic [7:0]        rdata,
    output logic [7:0]        status
);
    typedef struct packed {
        seq_state_e        st;
        rd_sel_e           rsel;
        logic [7:0]        status;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [7:0]        rdata;
    } ctl_t;

    ctl_t c_d, c_q;
    logic busy_state;
    logic wr_ok;

    assign busy_state = (c_q.st == ST_BUSY_PROG) || (c_q.st == ST_BUSY_ERASE);
    assign wr_ok      = cpu_wr && rewrite_en && !busy_state;

    always_comb begin
        c_d       = c_q;
        tmr_start = 1'b0;
        tmr_erase = 1'b0;
        prog_en   = 1'b0;
        erase_en  = 1'b0;

        if (cpu_rd) begin
            c_d.rdata = (c_q.rsel == RD_STATUS) ? c_q.status : cpu_byte;
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (wr_ok) begin
                    case (cpu_wdata)
                        CMD_READ_ARRAY:   c_d.rsel = RD_ARRAY;
                        CMD_READ_STATUS:  c_d.rsel = RD_STATUS;
                        CMD_CLEAR_STATUS: begin
                            c_d.status[SR_ERASE_ERR] = 1'b0;
                            c_d.status[SR_PROG_ERR]  = 1'b0;
                        end
                        CMD_PROGRAM:      c_d.st = ST_ARM_PROG;
                        CMD_ERASE:        c_d.st = ST_ARM_ERASE;
                        default:          ;
                    endcase
                end
            end
            ST_ARM_PROG: begin
                if (wr_ok) begin
                    c_d.addr             = cpu_addr;
                    c_d.data             = cpu_wdata;
                    c_d.st               = ST_BUSY_PROG;
                    c_d.rsel             = RD_STATUS;
                    c_d.status[SR_READY] = 1'b0;
                    tmr_start            = 1'b1;
                end
            end
            ST_ARM_ERASE: begin
                if (wr_ok) begin
                    if (cpu_wdata == CMD_ERASE_CONFIRM) begin
                        c_d.addr             = cpu_addr;
                        c_d.st               = ST_BUSY_ERASE;
                        c_d.rsel             = RD_STATUS;
                        c_d.status[SR_READY] = 1'b0;
                        tmr_start            = 1'b1;
                        tmr_erase            = 1'b1;
                    end else begin
                        c_d.status[SR_ERASE_ERR] = 1'b1;
                        c_d.status[SR_PROG_ERR]  = 1'b1;
                        c_d.st                   = ST_IDLE;
                    end
                end
            end
            ST_BUSY_PROG: begin
                if (tmr_done) begin
                    prog_en              = 1'b1;
                    c_d.status[SR_READY] = 1'b1;
                    if ((op_byte & c_q.data) != c_q.data) begin
                        c_d.status[SR_PROG_ERR] = 1'b1;
                    end
                    c_d.st = ST_IDLE;
                end
            end
            ST_BUSY_ERASE: begin
                if (tmr_done) begin
                    erase_en             = 1'b1;
                    c_d.status[SR_READY] = 1'b1;
                    c_d.st               = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q        <= '0;
            c_q.st     <= ST_IDLE;
            c_q.rsel   <= RD_ARRAY;
            c_q.status <= STATUS_RESET;
        end else begin
            c_q <= c_d;
        end
    end

    assign op_addr = c_q.addr;
    assign op_data = c_q.data;
    assign rdata   = c_q.rdata;
    assign status  = c_q.status;

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.status[6] == 1'b0) && (c_q.status[3:0] == 4'h0));

    // R2
    disabled_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !rewrite_en && !busy_state)
        |=> ($stable(c_q.st) && $stable(c_q.rsel) && $stable(c_q.status)));

    // R5
    clear_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && c_q.st == ST_IDLE && cpu_wdata == CMD_CLEAR_STATUS)
        |=> (c_q.status[5:4] == 2'b00 && c_q.status[7] == $past(c_q.status[7])));

    // R6
    prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && c_q.st == ST_ARM_PROG)
        |=> (c_q.st == ST_BUSY_PROG && c_q.rsel == RD_STATUS && !c_q.status[7]));

    // R10
    bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && c_q.st == ST_ARM_ERASE && cpu_wdata != CMD_ERASE_CONFIRM)
        |=> (c_q.status[5:4] == 2'b11 && c_q.st == ST_IDLE));

    // R12
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.rsel == RD_STATUS && !(wr_ok && c_q.st == ST_IDLE && cpu_wdata == CMD_READ_ARRAY))
        |=> (c_q.rsel == RD_STATUS));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int ADDR_W       = 6,
    parameter int BLK_W        = 4,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewrite_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [7:0]        cpu_rdata,
    output logic              ready_o
);
    logic              tmr_start, tmr_erase, tmr_busy, tmr_done;
    logic              prog_en, erase_en;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data, cpu_byte, op_byte, status;

    flash_seq_ctrl #(.ADDR_W(ADDR_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rewrite_en (rewrite_en),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_byte   (cpu_byte),
        .op_byte    (op_byte),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .tmr_erase  (tmr_erase),
        .prog_en    (prog_en),
        .erase_en   (erase_en),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .rdata      (cpu_rdata),
        .status     (status)
    );

    flash_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .erase_i (tmr_erase),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    flash_array_model #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) arr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .op_addr   (op_addr),
        .prog_en   (prog_en),
        .erase_en  (erase_en),
        .prog_data (op_data),
        .cpu_byte  (cpu_byte),
        .op_byte   (op_byte)
    );

    assign ready_o = !tmr_busy;

    // R8
    ready_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o == status[7]);

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
    localparam int ADDR_W = 6;
    localparam int BLK_W  = 4;
    localparam int PCYC   = 4;
    localparam int ECYC   = 10;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NBLK   = 1 << (ADDR_W - BLK_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rewrite_en = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_wr = 1'b0;
    logic              cpu_rd = 1'b0;
    logic [7:0]        cpu_rdata;
    logic              ready_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] mem_m [DEPTH];
    logic [7:0] sr_m;

    always #10 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rewrite_en(rewrite_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata), .ready_o(ready_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic count_busy(input string req, input int exp);
        int n = 0;
        while (ready_o == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(req, 8'(n), 8'(exp));
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    task automatic program_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        logic [7:0] v;
        logic [7:0] nv;
        wr(a, 8'h40);
        wr(a, d);
        check("R6 ready low after second cycle", {7'd0, ready_o}, 8'h00);
        count_busy("R8 program busy length", PCYC);
        nv = mem_m[a] & d;
        mem_m[a] = nv;
        if (nv != d) sr_m = sr_m | 8'h10;
        rd(a, v);
        check("R6/R12 status read after program", v, sr_m);
    endtask

    task automatic erase_block(input int b);
        logic [7:0] v;
        wr(ADDR_W'(b * (1 << BLK_W) + (1 << BLK_W) - 1), 8'h20);
        wr(ADDR_W'(b * (1 << BLK_W) + (1 << BLK_W) - 1), 8'hD0);
        count_busy("R8 erase busy length", ECYC);
        for (int i = 0; i < (1 << BLK_W); i++) mem_m[b * (1 << BLK_W) + i] = 8'hFF;
        rd('0, v);
        check("R7 status read after erase", v, sr_m);
    endtask

    task automatic compare_array(input string req);
        logic [7:0] v;
        wr('0, 8'hFF);
        for (int a = 0; a < DEPTH; a++) begin
            rd(ADDR_W'(a), v);
            check(req, v, mem_m[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) mem_m[a] = 8'hFF;
        sr_m = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 ready after reset", {7'd0, ready_o}, 8'h01);
        rd(6'd9, v);
        check("R1/R3 array read after reset", v, 8'hFF);

        // R2 writes ignored while disabled
        wr(6'd3, 8'h40);
        wr(6'd3, 8'h00);
        check("R2 ready stays high while disabled", {7'd0, ready_o}, 8'h01);
        rd(6'd3, v);
        check("R2 array unchanged while disabled", v, 8'hFF);
        wr(6'd3, 8'h70);
        rd(6'd3, v);
        check("R2 read selection unchanged while disabled", v, 8'hFF);
        rewrite_en = 1'b1;

        // R4 status read
        wr('0, 8'h70);
        rd('0, v);
        check("R4 status after reset", v, 8'h80);

        // R13 unknown codes
        wr('0, 8'h33);
        rd('0, v);
        check("R13 unknown code keeps status read", v, 8'h80);
        wr('0, 8'hD0);
        wr(6'd5, 8'h00);
        rd(6'd5, v);
        check("R13 stray code neither arms nor programs", v, 8'h80);
        compare_array("R13 array untouched by stray codes");

        // R6/R8 program sweep over every address
        for (int a = 0; a < DEPTH; a++) program_byte(ADDR_W'(a), pat(a));
        compare_array("R3/R6 array contents after program sweep");

        // R9 verify failure, then R5 clear
        program_byte(6'd0, ~pat(0));
        check("R9 program error flagged", sr_m, 8'h90);
        wr('0, 8'h50);
        sr_m = 8'h80;
        rd('0, v);
        check("R5 clear status leaves ready", v, 8'h80);
        program_byte(6'd1, pat(1));
        check("R9 exact program gives no error", sr_m, 8'h80);

        // R10 bad confirm
        wr(6'd20, 8'h20);
        wr(6'd20, 8'h55);
        check("R10 no busy after bad confirm", {7'd0, ready_o}, 8'h01);
        wr('0, 8'h70);
        rd('0, v);
        check("R10 both error bits set", v, 8'hB0);
        wr('0, 8'h50);
        rd('0, v);
        check("R5 clear removes both error bits", v, 8'h80);
        compare_array("R10 nothing erased after bad confirm");
        sr_m = 8'h80;

        // R7 erase each block, compare after each
        erase_block(2);
        compare_array("R7 block 2 erased, others kept");
        for (int b = 0; b < NBLK; b++) begin
            if (b != 2) begin
                erase_block(b);
                compare_array("R7 block erase");
            end
        end

        // R11 write and read on the completion edge
        wr(6'd7, 8'h40);
        @(negedge clk);
        cpu_addr = 6'd7; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        repeat (PCYC - 1) @(negedge clk);
        check("R8 still busy in final cycle", {7'd0, ready_o}, 8'h00);
        cpu_wdata = 8'hFF; cpu_wr = 1'b1; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        check("R8 ready after completion edge", {7'd0, ready_o}, 8'h01);
        check("R11 read on completion edge sees busy status", cpu_rdata, 8'h00);
        mem_m[7] = mem_m[7] & 8'h5A;
        rd(6'd7, v);
        check("R11/R12 dropped 0xFF keeps status read", v, 8'h80);
        compare_array("R11 program landed despite collision");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule